// File: doc/BRIEF.md
# Coin Credit Controller with Retimed Open Output

This block counts coins toward a fixed price of fifteen cents. Each clock cycle it may see a nickel pulse, a dime pulse, or neither. It keeps the running credit in a four-state machine with the states IDLE_0 (no credit), HAVE_5, HAVE_10 and FULL_15. When the credit reaches fifteen cents, the machine spends exactly one cycle in FULL_15 and then returns to IDLE_0.

The open indication is built twice from the same transition logic:

- The Moore path decodes FULL_15 straight from the state register.
- The retimed Mealy path detects the transition that enters FULL_15 from the current state and coin inputs, then captures that result in its own output flip-flop.

Because that flip-flop adds one cycle, the two open outputs rise and fall on the same clock edges. A designer can pick either path: the Mealy form has a shallow output path, and the Moore form needs no extra flop.

The named transitions are:

| Transition | From | Condition | To |
|---|---|---|---|
| T_REST | IDLE_0, HAVE_5, HAVE_10 | no coin | same state |
| T_N0 | IDLE_0 | nickel | HAVE_5 |
| T_D0 | IDLE_0 | dime | HAVE_10 |
| T_N5 | HAVE_5 | nickel | HAVE_10 |
| T_D5 | HAVE_5 | dime | FULL_15 |
| T_N10 | HAVE_10 | nickel | FULL_15 |
| T_D10 | HAVE_10 | dime | FULL_15 (saturating) |
| T_VEND | FULL_15 | any | IDLE_0 |

When both coins arrive in the same cycle, the machine treats them as a dime.

Top module: `vend_retimed_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the credit at code 0 (zero cents) and drives both open outputs low on the cycle after the reset edge.
- R2: A nickel alone adds five cents, moving the credit code 0→1, 1→2 and 2→3. The codes are 0=0c, 1=5c, 2=10c and 3=15c.
- R3: A dime alone moves the credit code 0→2 and 1→3.
- R4: A dime at code 2 (ten cents) saturates to code 3; the excess credit is discarded.
- R5: Code 3 lasts exactly one cycle and is followed by code 0. Any coin sampled during that cycle is ignored.
- R6: In codes 0 to 2, a cycle with no coin leaves the credit unchanged.
- R7: The Moore open output is high exactly in the cycles where the credit code is 3.
- R8: The registered Mealy open output equals the Moore open output on every cycle after reset.
- R9: A nickel and a dime in the same cycle act exactly as a dime alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle pulse: a five-cent coin |
| dime_i | input | 1 | One-cycle pulse: a ten-cent coin |
| credit_o | output | 2 | Current credit code (0/5/10/15 cents) |
| open_moore_o | output | 1 | Open, decoded from the state register |
| open_mealy_o | output | 1 | Open, Mealy transition detect through an output flop |

## Verification
The assertions assume that the coin inputs are already synchronous to the clock and are held for one cycle per coin. They make no assumption that the two coins are mutually exclusive. The bench changes the inputs only on the falling edge and holds each coin for a single cycle. On purpose, it includes cycles with both coins, coins during FULL_15, and dimes at ten cents. The reference model then checks the credit and both open paths on every cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        IDLE_0  = 2'd0,
        HAVE_5  = 2'd1,
        HAVE_10 = 2'd2,
        FULL_15 = 2'd3
    } credit_e;

endpackage

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    nickel,
    input  logic    dime,
    output credit_e state_q,
    output credit_e state_d
);

    logic dime_eff;
    logic nickel_eff;

    // Both coins together act as a dime.
    assign dime_eff   = dime;
    assign nickel_eff = nickel & ~dime;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_0: begin
                if (dime_eff)        state_d = HAVE_10;  // T_D0
                else if (nickel_eff) state_d = HAVE_5;   // T_N0
            end
            HAVE_5: begin
                if (dime_eff)        state_d = FULL_15;  // T_D5
                else if (nickel_eff) state_d = HAVE_10;  // T_N5
            end
            HAVE_10: begin
                if (dime_eff || nickel_eff)
                    state_d = FULL_15;                   // T_D10 / T_N10
            end
            FULL_15: state_d = IDLE_0;                   // T_VEND
            default: state_d = IDLE_0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE_0;
        else     state_q <= state_d;
    end

    a_r5_vend_one_cycle: assert property (@(posedge clk) disable iff (rst)
        state_q == FULL_15 |=> state_q == IDLE_0);

    a_r6_hold_no_coin: assert property (@(posedge clk) disable iff (rst)
        (state_q != FULL_15 && !nickel && !dime) |=> $stable(state_q));

    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        (state_q == HAVE_10 && dime) |=> state_q == FULL_15);

    a_r2_nickel_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == IDLE_0 && nickel && !dime) |=> state_q == HAVE_5);

    a_r9_both_is_dime: assert property (@(posedge clk) disable iff (rst)
        (state_q == IDLE_0 && nickel && dime) |=> state_q == HAVE_10);

endmodule

// File: rtl/vend_moore_dec.sv
module vend_moore_dec
    import vend_pkg::*;
(
    input  credit_e state_q,
    output logic    open_moore
);

    always_comb begin
        unique case (state_q)
            FULL_15: open_moore = 1'b1;
            default: open_moore = 1'b0;
        endcase
    end

endmodule

// File: rtl/vend_mealy_reg.sv
module vend_mealy_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_e state_q,
    input  credit_e state_d,
    output logic    open_mealy_q
);

    logic open_mealy_d;

    // Mealy open: this transition enters FULL_15.
    always_comb begin
        open_mealy_d = (state_q != FULL_15) && (state_d == FULL_15);
    end

    always_ff @(posedge clk) begin
        if (rst) open_mealy_q <= 1'b0;
        else     open_mealy_q <= open_mealy_d;
    end

    a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        open_mealy_q |=> !open_mealy_q);

endmodule

// File: rtl/vend_retimed_ctrl.sv
module vend_retimed_ctrl
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                nickel_i,
    input  logic                dime_i,
    output logic [CREDIT_W-1:0] credit_o,
    output logic                open_moore_o,
    output logic                open_mealy_o
);

    credit_e state_q;
    credit_e state_d;

    vend_credit_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .nickel  (nickel_i),
        .dime    (dime_i),
        .state_q (state_q),
        .state_d (state_d)
    );

    vend_moore_dec u_moore (
        .state_q    (state_q),
        .open_moore (open_moore_o)
    );

    vend_mealy_reg u_mealy (
        .clk          (clk),
        .rst          (rst),
        .state_q      (state_q),
        .state_d      (state_d),
        .open_mealy_q (open_mealy_o)
    );

    assign credit_o = state_q;

    a_r8_paths_match: assert property (@(posedge clk) disable iff (rst)
        open_moore_o == open_mealy_o);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (credit_o == '0 && !open_moore_o && !open_mealy_o));

endmodule

// File: tb/sim_vend_retimed_ctrl.sv
module sim_vend_retimed_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nickel_i = 1'b0;
    logic       dime_i = 1'b0;
    logic [1:0] credit_o;
    logic       open_moore_o;
    logic       open_mealy_o;

    int errors = 0;
    int checks = 0;
    int cents  = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    vend_retimed_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .nickel_i     (nickel_i),
        .dime_i       (dime_i),
        .credit_o     (credit_o),
        .open_moore_o (open_moore_o),
        .open_mealy_o (open_mealy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit n, input bit d, input string req);
        nickel_i = n;
        dime_i   = d;
        @(posedge clk);
        if (cents == 15) cents = 0;
        else if (d)      cents = (cents + 10 > 15) ? 15 : cents + 10;
        else if (n)      cents = cents + 5;
        @(negedge clk);
        nickel_i = 0;
        dime_i   = 0;
        check({req, " credit"}, credit_o, cents / 5);
        check("R7 moore open", open_moore_o, cents == 15);
        check("R8 mealy open", open_mealy_o, cents == 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 credit", credit_o, 0);
        check("R1 moore", open_moore_o, 0);
        check("R1 mealy", open_mealy_o, 0);

        step(0, 0, "R6");
        step(1, 0, "R2");
        step(0, 0, "R6");
        step(1, 0, "R2");
        step(1, 0, "R2");
        step(1, 0, "R5");  // coin in FULL_15 is ignored
        step(0, 1, "R3");
        step(0, 0, "R6");
        step(0, 1, "R4");  // saturation
        step(0, 1, "R5");
        step(1, 0, "R2");
        step(0, 1, "R3");
        step(0, 0, "R5");
        step(1, 1, "R9");
        step(1, 1, "R9");
        step(1, 1, "R5");
        step(1, 0, "R2");
        step(1, 1, "R9");

        for (int i = 0; i < 60; i++) begin
            step(i % 3 == 0, i % 5 == 1, "R8 mix");
        end

        // reset mid-credit
        step(1, 0, "R2");
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        cents = 0;
        check("R1 credit after reset", credit_o, 0);
        check("R1 mealy after reset", open_mealy_o, 0);
        step(0, 0, "R6");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule